// File: doc/BRIEF.md
# Peripheral Clock-Gate Controller

This block holds one disable bit per peripheral module. It turns each bit into a clock enable for that module's clock gate, and it screens register traffic so that a switched-off module can neither be written nor read. Firmware writes the whole disable vector in one cycle and can read it back. A module is active only when it is present in the build and its bit is clear. A parameter mask gives the set of present modules. An absent module's bit is stuck at 1 and its clock enable is never raised.

A change of a disable bit reaches the clock enable `TCY_CLKS` system clocks after the write, which is one instruction cycle. Each present module has its own four-state machine:

| State | Meaning |
|---|---|
| `PCG_RUN` | Clock on, bit clear. |
| `PCG_STOPPING` | Bit set, clock still on, counting down. |
| `PCG_HALTED` | Clock off, bit set. |
| `PCG_STARTING` | Bit cleared, clock still off, counting down. |

The machine has six transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| *request-off* | RUN | STOPPING | The bit is set. |
| *expire-off* | STOPPING | HALTED | The countdown reaches zero. |
| *cancel-off* | STOPPING | RUN | The bit is cleared before expiry. |
| *request-on* | HALTED | STARTING | The bit is cleared. |
| *expire-on* | STARTING | RUN | The countdown reaches zero. |
| *cancel-on* | STARTING | HALTED | The bit is set again before expiry. |

The clock enable comes straight from the state register, so it changes only on a system clock edge.

Register accesses arrive on a one-hot module-select bus with write and read qualifiers. A write strobe is passed to the selected module only while its clock is on. A read of a module whose clock is off returns zero and raises `rd_invalid`.

Top module: `periph_clk_gate_ctrl`

## Requirements
- R1: After reset, `dis_rd_data` equals the inverse of `PRESENT_MASK` and `mod_clk_en` equals `PRESENT_MASK`.
- R2: A cycle with `dis_wr_en` high loads `dis_wr_data` into the disable vector, and the new value is visible on `dis_rd_data` after that edge. Bits of absent modules ignore the write and read 1.
- R3: When a present module's bit is set, its `mod_clk_en` falls on the `TCY_CLKS`-th clock edge after the write edge.
- R4: When a present module's bit is cleared, its `mod_clk_en` rises on the `TCY_CLKS`-th clock edge after the write edge.
- R5: If a bit returns to its old value before the delay expires, the pending change is cancelled and `mod_clk_en` does not change. Writing a bit with its current value never changes `mod_clk_en`.
- R6: `mod_clk_en` of an absent module stays 0 whatever is written.
- R7: `mod_wr_stb[i]` is high in a cycle exactly when `bus_wr` is high, `bus_sel[i]` is high and `mod_clk_en[i]` is high.
- R8: When `bus_rd` is high and module i is selected with its clock on, `rd_data` carries slice i of `mod_rd_data` and `rd_invalid` is 0. When the selected module's clock is off, `rd_data` is 0 and `rd_invalid` is 1. With no read, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_wr_en | input | 1 | Write the disable vector this cycle |
| dis_wr_data | input | NUM_MOD | New disable vector; bit i is 1 to switch module i off |
| dis_rd_data | output | NUM_MOD | Current disable vector; absent modules read 1 |
| bus_sel | input | NUM_MOD | One-hot select of the module addressed by the register bus |
| bus_wr | input | 1 | Register write qualifier |
| bus_rd | input | 1 | Register read qualifier |
| mod_rd_data | input | NUM_MOD*DATA_W | Read data from each module; slice i belongs to module i |
| mod_clk_en | output | NUM_MOD | Clock enable for each module's clock gate |
| mod_wr_stb | output | NUM_MOD | Register write strobe passed to each module |
| rd_data | output | DATA_W | Read data returned to the bus |
| rd_invalid | output | 1 | The read addressed a module whose clock is off |

## Verification
The assertions assume that `bus_sel` has at most one bit set in any cycle. The read mux ORs the gated slices, and the invalid flag is formed from the select, so two selects would give a result with no meaning. The stimulus draws the select from a single index, or none, and never sets two bits. The delay checks assume that the disable vector changes only through `dis_wr_en`. The bench changes it with single-cycle writes, and with back-to-back writes where it tests cancellation.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    typedef enum logic [1:0] {
        PCG_RUN      = 2'd0,
        PCG_STOPPING = 2'd1,
        PCG_HALTED   = 2'd2,
        PCG_STARTING = 2'd3
    } pcg_state_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pcg_gate_fsm.sv
module pcg_gate_fsm
    import pcg_pkg::*;
#(
    parameter int unsigned TCY_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dis_nxt_i,
    input  logic dis_q_i,
    output logic clk_en_o
);

    localparam int unsigned CNT_W = cnt_width(TCY_CLKS);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TCY_CLKS - 1);
    localparam logic [CNT_W:0]   AGE_MAX  = {(CNT_W+1){1'b1}};

    pcg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PCG_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PCG_RUN: begin
                if (dis_nxt_i) begin
                    state_d = PCG_STOPPING;
                    cnt_d   = CNT_LOAD;
                end
            end
            PCG_STOPPING: begin
                if (!dis_nxt_i) begin
                    state_d = PCG_RUN;
                end else if (cnt_q == '0) begin
                    state_d = PCG_HALTED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PCG_HALTED: begin
                if (!dis_nxt_i) begin
                    state_d = PCG_STARTING;
                    cnt_d   = CNT_LOAD;
                end
            end
            PCG_STARTING: begin
                if (dis_nxt_i) begin
                    state_d = PCG_HALTED;
                end else if (cnt_q == '0) begin
                    state_d = PCG_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PCG_RUN;
        endcase
    end

    // output logic
    always_comb begin
        unique case (state_q)
            PCG_RUN, PCG_STOPPING:    clk_en_o = 1'b1;
            PCG_HALTED, PCG_STARTING: clk_en_o = 1'b0;
            default:                  clk_en_o = 1'b0;
        endcase
    end

    // checker: cycles spent with the bit disagreeing with the enable
    logic [CNT_W:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (dis_q_i == !clk_en_o) begin
            age_q <= '0;
        end else if (age_q != AGE_MAX) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R3
    off_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> ($past(age_q) == (CNT_W+1)'(TCY_CLKS - 1)) && dis_q_i);

    // R4
    on_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o) |-> ($past(age_q) == (CNT_W+1)'(TCY_CLKS - 1)) && !dis_q_i);

    // R5
    steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q_i == !clk_en_o) |=> $stable(clk_en_o));

endmodule

// File: rtl/pcg_access_gate.sv
module pcg_access_gate #(
    parameter int unsigned NUM_MOD = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MOD-1:0]        mod_en_i,
    input  logic [NUM_MOD-1:0]        bus_sel_i,
    input  logic                      bus_wr_i,
    input  logic                      bus_rd_i,
    input  logic [NUM_MOD*DATA_W-1:0] mod_rd_data_i,
    output logic [NUM_MOD-1:0]        mod_wr_stb_o,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      rd_invalid_o
);

    logic [NUM_MOD-1:0] sel_live;
    logic [NUM_MOD-1:0] sel_dead;

    assign sel_live     = bus_sel_i & mod_en_i;
    assign sel_dead     = bus_sel_i & ~mod_en_i;
    assign mod_wr_stb_o = bus_wr_i ? sel_live : '0;
    assign rd_invalid_o = bus_rd_i && (sel_dead != '0);

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < int'(NUM_MOD); i++) begin
            if (bus_rd_i && sel_live[i]) begin
                rd_data_o = rd_data_o | mod_rd_data_i[i*DATA_W +: DATA_W];
            end
        end
    end

    // bus contract: one module at a time
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel_i));

    // R8
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid_o |-> (rd_data_o == '0));

endmodule

// File: rtl/periph_clk_gate_ctrl.sv
module periph_clk_gate_ctrl #(
    parameter int unsigned          NUM_MOD      = 8,
    parameter int unsigned          DATA_W       = 16,
    parameter int unsigned          TCY_CLKS     = 2,
    parameter logic [NUM_MOD-1:0]   PRESENT_MASK = 8'b1011_1111
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dis_wr_en,
    input  logic [NUM_MOD-1:0]        dis_wr_data,
    output logic [NUM_MOD-1:0]        dis_rd_data,
    input  logic [NUM_MOD-1:0]        bus_sel,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [NUM_MOD*DATA_W-1:0] mod_rd_data,
    output logic [NUM_MOD-1:0]        mod_clk_en,
    output logic [NUM_MOD-1:0]        mod_wr_stb,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_invalid
);

    logic [NUM_MOD-1:0] dis_q;
    logic [NUM_MOD-1:0] dis_nxt;

    for (genvar i = 0; i < int'(NUM_MOD); i++) begin : g_mod
        if (PRESENT_MASK[i]) begin : g_present
            assign dis_nxt[i] = dis_wr_en ? dis_wr_data[i] : dis_q[i];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dis_q[i] <= 1'b0;
                else        dis_q[i] <= dis_nxt[i];
            end

            pcg_gate_fsm #(
                .TCY_CLKS (TCY_CLKS)
            ) u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .dis_nxt_i (dis_nxt[i]),
                .dis_q_i   (dis_q[i]),
                .clk_en_o  (mod_clk_en[i])
            );
        end else begin : g_absent
            assign dis_nxt[i]    = 1'b1;
            assign dis_q[i]      = 1'b1;
            assign mod_clk_en[i] = 1'b0;
        end
    end

    assign dis_rd_data = dis_q;

    pcg_access_gate #(
        .NUM_MOD (NUM_MOD),
        .DATA_W  (DATA_W)
    ) u_access (
        .clk           (clk),
        .rst_n         (rst_n),
        .mod_en_i      (mod_clk_en),
        .bus_sel_i     (bus_sel),
        .bus_wr_i      (bus_wr),
        .bus_rd_i      (bus_rd),
        .mod_rd_data_i (mod_rd_data),
        .mod_wr_stb_o  (mod_wr_stb),
        .rd_data_o     (rd_data),
        .rd_invalid_o  (rd_invalid)
    );

    // R7
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_wr_stb & ~mod_clk_en) == '0);

    // R6
    absent_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_clk_en & ~PRESENT_MASK) == '0 && (dis_rd_data & ~PRESENT_MASK) == ~PRESENT_MASK);

endmodule

// File: tb/tb_periph_clk_gate_ctrl.sv
module tb_periph_clk_gate_ctrl;

    localparam int N   = 8;
    localparam int DW  = 16;
    localparam int TCY = 2;
    localparam logic [N-1:0] PM = 8'b1011_1111;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            dis_wr_en = 1'b0;
    logic [N-1:0]    dis_wr_data = '0;
    logic [N-1:0]    dis_rd_data;
    logic [N-1:0]    bus_sel = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [N*DW-1:0] mod_rd_data;
    logic [N-1:0]    mod_clk_en;
    logic [N-1:0]    mod_wr_stb;
    logic [DW-1:0]   rd_data;
    logic            rd_invalid;

    periph_clk_gate_ctrl #(
        .NUM_MOD (N), .DATA_W (DW), .TCY_CLKS (TCY), .PRESENT_MASK (PM)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .dis_wr_en (dis_wr_en), .dis_wr_data (dis_wr_data), .dis_rd_data (dis_rd_data),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .mod_rd_data (mod_rd_data), .mod_clk_en (mod_clk_en), .mod_wr_stb (mod_wr_stb),
        .rd_data (rd_data), .rd_invalid (rd_invalid)
    );

    int    m_dis [N];
    int    m_en  [N];
    int    m_cnt [N];
    int    vecs = 0;
    int    errs = 0;
    int    cyc  = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    initial begin
        for (int i = 0; i < N; i++) mod_rd_data[i*DW +: DW] = DW'(16'hA000 + i * 16'h0111);
    end

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_dis[i] = PM[i] ? 0 : 1;
            m_en[i]  = PM[i] ? 1 : 0;
            m_cnt[i] = 0;
        end
    endfunction

    initial model_reset();

    function automatic void check(string what, string req, logic [63:0] act, logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endfunction

    task automatic compare();
        logic [N-1:0]  e_en, e_rd, e_wr;
        logic [DW-1:0] e_data;
        logic          e_inv;
        e_data = '0;
        e_inv  = 1'b0;
        for (int i = 0; i < N; i++) begin
            e_en[i] = (m_en[i] != 0);
            e_rd[i] = (m_dis[i] != 0);
            e_wr[i] = bus_wr && bus_sel[i] && (m_en[i] != 0);
            if (bus_rd && bus_sel[i]) begin
                if (m_en[i] != 0) e_data = mod_rd_data[i*DW +: DW];
                else              e_inv  = 1'b1;
            end
        end
        check("clk_en",   cur_req, 64'(mod_clk_en),  64'(e_en));
        check("readback", cur_req, 64'(dis_rd_data), 64'(e_rd));
        check("wr_stb",   cur_req, 64'(mod_wr_stb),  64'(e_wr));
        check("rd_data",  cur_req, 64'(rd_data),     64'(e_data));
        check("rd_inv",   cur_req, 64'(rd_invalid),  64'(e_inv));
    endtask

    // reference model: advances on each edge, compared 2 ns later
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int i = 0; i < N; i++) begin
                if (PM[i]) begin
                    int nd, want;
                    nd   = dis_wr_en ? int'(dis_wr_data[i]) : m_dis[i];
                    m_dis[i] = nd;
                    want = (nd == 0) ? 1 : 0;
                    if (want == m_en[i])     m_cnt[i] = 0;
                    else if (m_cnt[i] == TCY) begin
                        m_en[i]  = want;
                        m_cnt[i] = 0;
                    end else                 m_cnt[i]++;
                end
            end
        end
        #2;
        if (!done) compare();
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_dis(logic [N-1:0] v);
        @(negedge clk);
        dis_wr_en   = 1'b1;
        dis_wr_data = v;
        @(negedge clk);
        dis_wr_en   = 1'b0;
    endtask

    task automatic sweep(bit do_wr, bit do_rd);
        for (int m = 0; m < N; m++) begin
            @(negedge clk);
            bus_sel = N'(1) << m;
            bus_wr  = do_wr;
            bus_rd  = do_rd;
        end
        @(negedge clk);
        bus_sel = '0;
        bus_wr  = 1'b0;
        bus_rd  = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errs++;
            $display("FAIL %s watchdog: actual %0d cycles expected completion", cur_req, cyc);
            finish_run();
        end
    end

    initial begin
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        step(3);

        cur_req = "R2";
        wr_dis(8'hFF);
        step(4);
        wr_dis(8'h00);
        step(4);

        cur_req = "R3";
        wr_dis(8'h01);
        step(5);
        wr_dis(8'h81);
        step(5);

        cur_req = "R4";
        wr_dis(8'h80);
        step(5);
        wr_dis(8'h00);
        step(5);

        cur_req = "R5";
        @(negedge clk); dis_wr_en = 1'b1; dis_wr_data = 8'h02;
        @(negedge clk); dis_wr_data = 8'h00;
        @(negedge clk); dis_wr_en = 1'b0;
        step(4);
        wr_dis(8'h00);
        step(4);

        cur_req = "R6";
        wr_dis(8'h40);
        step(4);
        wr_dis(8'h00);
        step(4);

        cur_req = "R7";
        wr_dis(8'h05);
        step(4);
        sweep(1'b1, 1'b0);

        cur_req = "R8";
        sweep(1'b0, 1'b1);
        wr_dis(8'h00);
        sweep(1'b0, 1'b1);
        step(2);

        cur_req = "R5";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            dis_wr_en   = ($urandom % 3) == 0;
            dis_wr_data = N'($urandom);
            begin
                int idx;
                idx = $urandom % (N + 1);
                bus_sel = (idx == N) ? '0 : (N'(1) << idx);
            end
            bus_wr = $urandom % 2;
            bus_rd = $urandom % 2;
        end
        @(negedge clk);
        dis_wr_en = 1'b0;
        bus_sel   = '0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        step(4);

        finish_run();
    end

endmodule